// File: doc/BRIEF.md
# Striping Region Address Decoder

This block turns the physical address of a request into the index of the master interface that should serve it, or into a decode-error flag. The low 44 bits of the address space are split into a fixed set of regions. Addresses that fall between the regions are reserved. Each region has a 3-bit routing code. A code either sends the whole region to one master interface, or spreads the region over the memory ports in 256-byte stripes. The memory ports are always the highest-numbered master interfaces.

The routing codes are copied from a configuration bus while reset is high and are frozen when reset falls. A request is one cycle of `req_valid_i` with its address. One cycle later the block presents a registered response: a valid flag, the target index and a decode-error bit. The block is parameterised by the number of master interfaces, the number of memory ports and the physical address width (32 to 48 bits).

Top module: `addr_stripe_decoder`

## Requirements
- R1: `rsp_valid_o` equals `req_valid_i` from the previous clock edge. While reset is high, and in any cycle without a valid response, `rsp_valid_o`, `rsp_decerr_o` and `rsp_target_o` are all 0.
- R2: A request whose address has any bit at position 44 or above set gives `rsp_decerr_o`=1.
- R3: The region table is as follows, written as base and exclusive end in 44-bit hex:
  - region 0: [0x000_0000_0000, 0x000_8000_0000)
  - region 1: [0x000_8000_0000, 0x001_0000_0000)
  - region 2: [0x008_0000_0000, 0x010_0000_0000)
  - region 3: [0x010_0000_0000, 0x020_0000_0000)
  - region 4: [0x080_0000_0000, 0x100_0000_0000)
  - region 5: [0x800_0000_0000, 0x1000_0000_0000)

  Any address in no listed region is reserved and gives `rsp_decerr_o`=1.
- R4: Region k takes its code from `cfg_map_i[3k+2:3k]`. A code c from 0 to 6 routes the region to master interface c, with `rsp_decerr_o`=0.
- R5: A code from 0 to 6 that is equal to or greater than NUM_MI gives `rsp_decerr_o`=1.
- R6: The codes are sampled only while `rst` is high. Changes on `cfg_map_i` after reset do not change any decode result.
- R7: Code 7 with NUM_MEM=1 routes every address in the region to interface NUM_MI-1.
- R8: Code 7 with NUM_MEM=2 routes to interface NUM_MI-2+addr[8].
- R9: Code 7 with NUM_MEM=3 stripes over the two highest interfaces only: NUM_MI-2+addr[8].
- R10: Code 7 with NUM_MEM of 4 or more routes to interface NUM_MI-4+addr[9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; routing codes are captured while it is high |
| cfg_map_i | input | 18 | Routing codes, 3 bits per region, with region k at bits [3k+2:3k] |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | PA_WIDTH | Request physical address |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_target_o | output | 3 | Target master-interface index |
| rsp_decerr_o | output | 1 | Decode error |

## Verification
The hardest cases to reach from the ports are the stripe variants and the absent-target error. Each stripe rule and the absent-target check depend on an elaboration parameter, so a single instance can show only one of them. The bench therefore drives five instances from the same inputs: four with seven interfaces and one to four memory ports, and one with only five interfaces. It resets them with routing codes chosen for each scenario, then walks addresses through every region with address bits 9:8 stepping through all four values. A separate pass changes the configuration bus after reset to show that the captured codes stay frozen.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int MAP_BITS     = 44;
    localparam int CODE_W       = 3;
    localparam int TGT_W        = 3;
    localparam int NUM_REGIONS  = 6;
    localparam int REGION_IDX_W = $clog2(NUM_REGIONS);
    localparam int STRIPE_LSB   = 8;

    typedef logic [MAP_BITS:0]       ext_addr_t;
    typedef logic [CODE_W-1:0]       map_code_t;
    typedef logic [TGT_W-1:0]        tgt_idx_t;

    localparam map_code_t CODE_STRIPE = 3'd7;

    typedef struct packed {
        logic                    hit;
        logic [REGION_IDX_W-1:0] idx;
    } region_hit_t;

    typedef struct packed {
        logic     valid;
        logic     decerr;
        tgt_idx_t target;
    } decode_rsp_t;

    function automatic ext_addr_t region_base(input int r);
        case (r)
            0:       return 45'h000_0000_0000;
            1:       return 45'h000_8000_0000;
            2:       return 45'h008_0000_0000;
            3:       return 45'h010_0000_0000;
            4:       return 45'h080_0000_0000;
            default: return 45'h800_0000_0000;
        endcase
    endfunction

    function automatic ext_addr_t region_end(input int r);
        case (r)
            0:       return 45'h000_8000_0000;
            1:       return 45'h001_0000_0000;
            2:       return 45'h010_0000_0000;
            3:       return 45'h020_0000_0000;
            4:       return 45'h100_0000_0000;
            default: return 45'h1000_0000_0000;
        endcase
    endfunction

    function automatic int stripe_ways(input int n_mem);
        if (n_mem >= 4)      return 4;
        else if (n_mem >= 2) return 2;
        else                 return 1;
    endfunction

endpackage

// File: rtl/region_lookup.sv
module region_lookup
    import addr_dec_pkg::*;
#(
    parameter int PA_WIDTH = 48
) (
    input  logic [PA_WIDTH-1:0] addr_i,
    output logic                oob_o,
    output region_hit_t         hit_o
);

    logic [MAP_BITS-1:0]    low_addr;
    ext_addr_t              ext_addr;
    logic [NUM_REGIONS-1:0] match;

    generate
        if (PA_WIDTH > MAP_BITS) begin : g_wide
            assign oob_o    = |addr_i[PA_WIDTH-1:MAP_BITS];
            assign low_addr = addr_i[MAP_BITS-1:0];
        end else begin : g_narrow
            assign oob_o    = 1'b0;
            assign low_addr = MAP_BITS'(addr_i);
        end
    endgenerate

    assign ext_addr = {1'b0, low_addr};

    generate
        for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
            assign match[r] = (ext_addr >= region_base(r)) &&
                              (ext_addr <  region_end(r));
        end
    endgenerate

    always_comb begin
        hit_o = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit_o.hit = 1'b1;
                hit_o.idx = REGION_IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/route_resolve.sv
module route_resolve
    import addr_dec_pkg::*;
#(
    parameter int NUM_MI  = 7,
    parameter int NUM_MEM = 4
) (
    input  map_code_t  code_i,
    input  logic [1:0] stripe_sel_i,
    output tgt_idx_t   tgt_o,
    output logic       absent_o
);

    localparam int WAYS        = stripe_ways(NUM_MEM);
    localparam int STRIPE_BASE = NUM_MI - WAYS;

    tgt_idx_t stripe_off;

    generate
        if (WAYS == 4) begin : g_four
            assign stripe_off = TGT_W'(stripe_sel_i);
        end else if (WAYS == 2) begin : g_two
            assign stripe_off = TGT_W'(stripe_sel_i[0]);
        end else begin : g_one
            assign stripe_off = '0;
        end
    endgenerate

    always_comb begin
        if (code_i == CODE_STRIPE) begin
            tgt_o    = TGT_W'(STRIPE_BASE) + stripe_off;
            absent_o = 1'b0;
        end else begin
            tgt_o    = code_i;
            absent_o = (int'(code_i) >= NUM_MI);
        end
    end

endmodule

// File: rtl/addr_stripe_decoder.sv
module addr_stripe_decoder
    import addr_dec_pkg::*;
#(
    parameter int NUM_MI   = 7,
    parameter int NUM_MEM  = 4,
    parameter int PA_WIDTH = 48
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_REGIONS*CODE_W-1:0] cfg_map_i,
    input  logic                          req_valid_i,
    input  logic [PA_WIDTH-1:0]           req_addr_i,
    output logic                          rsp_valid_o,
    output logic [TGT_W-1:0]              rsp_target_o,
    output logic                          rsp_decerr_o
);

    localparam int WAYS = stripe_ways(NUM_MEM);

    map_code_t   map_q [NUM_REGIONS];
    region_hit_t hit;
    logic        oob;
    map_code_t   sel_code;
    tgt_idx_t    route_tgt;
    logic        absent;
    logic        err;
    decode_rsp_t rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                map_q[r] <= cfg_map_i[r*CODE_W +: CODE_W];
            end
        end
    end

    region_lookup #(.PA_WIDTH(PA_WIDTH)) u_lookup (
        .addr_i (req_addr_i),
        .oob_o  (oob),
        .hit_o  (hit)
    );

    assign sel_code = map_q[hit.idx];

    route_resolve #(.NUM_MI(NUM_MI), .NUM_MEM(NUM_MEM)) u_route (
        .code_i       (sel_code),
        .stripe_sel_i (req_addr_i[STRIPE_LSB +: 2]),
        .tgt_o        (route_tgt),
        .absent_o     (absent)
    );

    assign err = oob || !hit.hit || absent;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid  <= req_valid_i;
            rsp_q.decerr <= req_valid_i && err;
            rsp_q.target <= (req_valid_i && !err) ? route_tgt : '0;
        end
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_target_o = rsp_q.target;
    assign rsp_decerr_o = rsp_q.decerr;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid_o == $past(req_valid_i)));

    // R3
    reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !hit.hit) |=> rsp_decerr_o);

    // R5
    present_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_decerr_o) |-> (int'(rsp_target_o) < NUM_MI));

    // R6
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(map_q[0]) && $stable(map_q[1]) && $stable(map_q[2]) &&
                         $stable(map_q[3]) && $stable(map_q[4]) && $stable(map_q[5])));

    // R10
    stripe_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && hit.hit && !oob && sel_code == CODE_STRIPE) |=>
        (!rsp_decerr_o && int'(rsp_target_o) >= NUM_MI - WAYS));

    generate
        if (PA_WIDTH > MAP_BITS) begin : g_oob_chk
            // R2
            high_addr_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid_i && |req_addr_i[PA_WIDTH-1:MAP_BITS]) |=> rsp_decerr_o);
        end
    endgenerate

endmodule

// File: tb/addr_stripe_decoder_bench.sv
module addr_stripe_decoder_bench;

    localparam int NDUT = 5;
    localparam int NMI  [NDUT] = '{7, 7, 7, 7, 5};
    localparam int NMEM [NDUT] = '{1, 2, 3, 4, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] cfg = '0;
    logic [17:0] cfg_used = '0;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic        rv [NDUT];
    logic [2:0]  rt [NDUT];
    logic        re [NDUT];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    generate
        for (genvar k = 0; k < NDUT; k++) begin : g_dut
            addr_stripe_decoder #(.NUM_MI(NMI[k]), .NUM_MEM(NMEM[k]), .PA_WIDTH(48))
            u_addr_stripe_decoder (
                .clk          (clk),
                .rst          (rst),
                .cfg_map_i    (cfg),
                .req_valid_i  (req_valid),
                .req_addr_i   (req_addr),
                .rsp_valid_o  (rv[k]),
                .rsp_target_o (rt[k]),
                .rsp_decerr_o (re[k])
            );
        end
    endgenerate

    function automatic logic [47:0] rbase(input int r);
        case (r)
            0: return 48'h0;
            1: return 48'h0_8000_0000;
            2: return 48'h8_0000_0000;
            3: return 48'h10_0000_0000;
            4: return 48'h80_0000_0000;
            default: return 48'h800_0000_0000;
        endcase
    endfunction

    function automatic logic [47:0] rlimit(input int r);
        case (r)
            0: return 48'h0_8000_0000;
            1: return 48'h1_0000_0000;
            2: return 48'h10_0000_0000;
            3: return 48'h20_0000_0000;
            4: return 48'h100_0000_0000;
            default: return 48'h1000_0000_0000;
        endcase
    endfunction

    function automatic void model(input logic [47:0] a, input logic [17:0] c,
                                  input int nmi, input int nmem,
                                  output logic err, output logic [2:0] tgt);
        int reg_i = -1;
        int code;
        err = 1'b0;
        tgt = '0;
        for (int r = 0; r < 6; r++)
            if (a >= rbase(r) && a < rlimit(r)) reg_i = r;
        if (a[47:44] != 0 || reg_i < 0) begin
            err = 1'b1;
            return;
        end
        code = int'(c[reg_i*3 +: 3]);
        if (code < 7) begin
            if (code >= nmi) err = 1'b1;
            else tgt = 3'(code);
        end else if (nmem == 1) tgt = 3'(nmi - 1);
        else if (nmem <= 3)     tgt = 3'(nmi - 2 + int'(a[8]));
        else                    tgt = 3'(nmi - 4 + int'(a[9:8]));
    endfunction

    function automatic string stripe_tag(input int nmem);
        case (nmem)
            1: return "R7";
            2: return "R8";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int k, input logic v, input logic e,
                         input logic [2:0] t);
        n_checks++;
        if (rv[k] !== v || re[k] !== e || rt[k] !== t) begin
            n_fail++;
            $display("FAIL %s dut%0d: got v=%0b e=%0b t=%0d, expected v=%0b e=%0b t=%0d",
                     req, k, rv[k], re[k], rt[k], v, e, t);
        end
    endtask

    task automatic apply_reset(input logic [17:0] c);
        @(negedge clk);
        rst = 1'b1;
        cfg = c;
        cfg_used = c;
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NDUT; k++) check("R1", k, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic probe(input logic [47:0] a, input string req, input bit striped);
        logic       e;
        logic [2:0] t;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        #1;
        for (int k = 0; k < NDUT; k++) begin
            model(a, cfg_used, NMI[k], NMEM[k], e, t);
            check(striped ? stripe_tag(NMEM[k]) : req, k, 1'b1, e, t);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_idle;
        @(posedge clk);
        #1;
        for (int k = 0; k < NDUT; k++) check("R1", k, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_direct;
        apply_reset({3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0});
        for (int r = 0; r < 6; r++) begin
            probe(rbase(r) + 48'h140, (r == 5) ? "R5" : "R4", 1'b0);
            probe(rlimit(r) - 48'h1, (r == 5) ? "R5" : "R4", 1'b0);
        end
        t_idle;
        apply_reset({3'd6, 3'd6, 3'd0, 3'd2, 3'd3, 3'd1});
        for (int r = 0; r < 6; r++) probe(rbase(r) + 48'h20, "R5", 1'b0);
    endtask

    task automatic t_stripe;
        apply_reset({6{3'd7}});
        for (int r = 0; r < 6; r++)
            for (int s = 0; s < 4; s++)
                probe(rbase(r) + 48'(s * 256) + 48'h3c, "", 1'b1);
    endtask

    task automatic t_reserved;
        apply_reset({6{3'd7}});
        probe(48'h1_0000_0000, "R3", 1'b0);
        probe(48'h7_ffff_ffff, "R3", 1'b0);
        probe(48'h20_0000_0000, "R3", 1'b0);
        probe(48'h7ff_ffff_ff00, "R3", 1'b0);
    endtask

    task automatic t_high;
        apply_reset({6{3'd0}});
        probe(48'h1000_0000_0000, "R2", 1'b0);
        probe(48'h8000_0000_0100, "R2", 1'b0);
        probe(48'h4800_0000_0000, "R2", 1'b0);
    endtask

    task automatic t_freeze;
        apply_reset({3'd1, 3'd0, 3'd7, 3'd2, 3'd0, 3'd3});
        @(negedge clk);
        cfg = {6{3'd6}};
        for (int r = 0; r < 6; r++) probe(rbase(r) + 48'h300, "R6", 1'b0);
    endtask

    initial begin
        t_direct();
        t_stripe();
        t_reserved();
        t_high();
        t_freeze();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule